// File: doc/BRIEF.md
# DMA Bus Cycle Reply-Timeout and Parity Supervisor

This block watches every DMA read cycle that a bus master performs and decides whether the cycle succeeded. When the address-enable phase of a cycle ends, it starts a reply timer. The timer stops on the first bus reply. If no reply arrives before the timer runs out, the timer clears itself and raises a DMA error. The block also raises the error when memory reports bad parity, which it sees as both parity bits high at the moment the reply drops.

When the data-in strobe drops, the block emits a one-cycle completion pulse. If the error is set at that point and this word has not yet been retried, it asks the bus engine to read the same location once more and says nothing to the host. If the retry also fails, it raises a host-visible error flag instead. A clean completion re-arms the one-retry allowance. A new DMA request clears the error latch and the host flag. The bus protocol engine that issues the cycles sits outside this block.

Top module: `dma_cycle_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, `dma_err`, `dma_done`, `retry_req` and `host_err` are all 0.
- R2: When `addr_en` goes from 1 to 0, the timer starts at the clock edge that sees the low value. If `reply` stays low, `dma_err` goes high exactly TIMEOUT_CYCLES (default 128) edges later, and not earlier.
- R3: A `reply` seen high while the timer runs stops and clears the timer, so no timeout error follows, however long the block then waits.
- R4: At the edge where `reply` is first seen low after being high, `dma_err` is set only if `par_hi` and `par_lo` were both 1 in the last cycle `reply` was high. Either bit alone does not set it.
- R5: `dma_req` high at an edge clears `dma_err` and `host_err` at that edge. It wins over a timeout or parity error detected at the same edge.
- R6: `dma_done` is high for exactly the one cycle after the edge at which `din_strobe` is first seen low after being high.
- R7: If the error is present when completion is detected and no retry is pending for this word, `retry_req` pulses for one cycle with `dma_done`, and `host_err` stays 0.
- R8: If the error is present at completion and a retry was already used, `host_err` goes high instead of `retry_req` and stays high until the next `dma_req`. The retry allowance then re-arms for the next word.
- R9: A completion with no error re-arms the retry allowance. A later failing completion requests a retry again rather than reporting to the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | New DMA request; clears error state |
| addr_en | input | 1 | Address phase active; its falling edge starts the timer |
| reply | input | 1 | Bus reply from the slave |
| par_hi | input | 1 | Upper parity status bit from memory |
| par_lo | input | 1 | Lower parity status bit from memory |
| din_strobe | input | 1 | Data-in strobe; its falling edge marks completion |
| dma_err | output | 1 | Error latch: timeout or memory parity failure |
| dma_done | output | 1 | One-cycle completion pulse |
| retry_req | output | 1 | One-cycle request to read the same location again |
| host_err | output | 1 | Error reported to the host after the retry has also failed |

## Verification
The bench samples `dma_err` one edge before and exactly at the timeout limit. A timer that is off by one, or that counts from the wrong edge of `addr_en`, fails one of those two samples. It drives each parity bit on its own to catch a design that flags on either bit rather than both. It also lets a reply arrive mid-count and then waits well past the limit, which catches a timer that is not cleared by the reply. It walks the retry counter through fail-fail, fail-success-fail and a request arriving with a parity failure at the same edge. A design that reports on the first failure, never re-arms the retry, or lets an error set win over a request would show the wrong `retry_req` or `host_err`.

// File: rtl/dma_cycle_guard.sv
module dma_cycle_guard #(
  parameter int TIMEOUT_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic addr_en,
  input  logic reply,
  input  logic par_hi,
  input  logic par_lo,
  input  logic din_strobe,
  output logic dma_err,
  output logic dma_done,
  output logic retry_req,
  output logic host_err
);

  localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic          aen_q, rpl_q, din_q;
  logic [1:0]    par_q;
  logic          run;
  logic [CW-1:0] cnt;
  logic          err, tried, done, retry, host;

  wire aen_fall = aen_q & ~addr_en;
  wire rpl_fall = rpl_q & ~reply;
  wire din_fall = din_q & ~din_strobe;
  wire expire   = run & ~reply & (cnt == LAST);
  wire par_bad  = rpl_fall & (&par_q);
  wire err_eff  = ~dma_req & (err | expire | par_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aen_q <= 1'b0;
      rpl_q <= 1'b0;
      din_q <= 1'b0;
      par_q <= 2'b00;
      run   <= 1'b0;
      cnt   <= '0;
      err   <= 1'b0;
      tried <= 1'b0;
      done  <= 1'b0;
      retry <= 1'b0;
      host  <= 1'b0;
    end else begin
      aen_q <= addr_en;
      rpl_q <= reply;
      din_q <= din_strobe;
      par_q <= {par_hi, par_lo};

      if (aen_fall) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (reply || expire) begin
          run <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      err   <= err_eff;
      done  <= din_fall;
      retry <= din_fall & err_eff & ~tried;
      if (din_fall) tried <= err_eff & ~tried;

      if (dma_req)                           host <= 1'b0;
      else if (din_fall && err_eff && tried) host <= 1'b1;
    end
  end

  assign dma_err   = err;
  assign dma_done  = done;
  assign retry_req = retry;
  assign host_err  = host;

endmodule

module dma_cycle_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_req,
  input logic din_strobe,
  input logic dma_err,
  input logic dma_done,
  input logic retry_req,
  input logic host_err
);

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> (!dma_err && !host_err)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_done); // R6

  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> ($past(din_strobe, 2) && !$past(din_strobe))); // R6

  AST_RETRY_HAS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> (dma_err && dma_done)); // R7

  AST_REPORT_NOT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_err) |-> (!retry_req && dma_done)); // R8

endmodule

bind dma_cycle_guard dma_cycle_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .din_strobe(din_strobe),
  .dma_err(dma_err), .dma_done(dma_done), .retry_req(retry_req), .host_err(host_err)
);

// File: tb/sim_dma_cycle_guard.sv
module sim_dma_cycle_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 128;

  logic clk = 1'b0;
  logic rst_n, dma_req, addr_en, reply, par_hi, par_lo, din_strobe;
  logic dma_err, dma_done, retry_req, host_err;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cycle_guard #(.TIMEOUT_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .addr_en(addr_en), .reply(reply),
    .par_hi(par_hi), .par_lo(par_lo), .din_strobe(din_strobe),
    .dma_err(dma_err), .dma_done(dma_done), .retry_req(retry_req), .host_err(host_err));

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(string req, logic [1:0] par, logic e_err, logic e_retry, logic e_host);
    dma_req = 1'b1; tick();
    dma_req = 1'b0; addr_en = 1'b1; tick();
    addr_en = 1'b0; tick();
    reply = 1'b1; din_strobe = 1'b1; {par_hi, par_lo} = par; tick(2);
    reply = 1'b0; din_strobe = 1'b0; tick();
    chk(req, "dma_done at completion", dma_done, 1'b1);
    chk(req, "dma_err at completion", dma_err, e_err);
    chk(req, "retry_req at completion", retry_req, e_retry);
    chk(req, "host_err at completion", host_err, e_host);
    {par_hi, par_lo} = 2'b00; tick();
    chk(req, "dma_done one cycle", dma_done, 1'b0);
    chk(req, "retry_req one cycle", retry_req, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; dma_req = 0; addr_en = 0; reply = 0; par_hi = 0; par_lo = 0; din_strobe = 0;
    tick(3);
    chk("R1", "dma_err in reset", dma_err, 1'b0);
    chk("R1", "host_err in reset", host_err, 1'b0);
    rst_n = 1'b1; tick();
    chk("R1", "dma_err after reset", dma_err, 1'b0);
    chk("R1", "dma_done after reset", dma_done, 1'b0);
    chk("R1", "retry_req after reset", retry_req, 1'b0);
    chk("R1", "host_err after reset", host_err, 1'b0);
  endtask

  task automatic t_good;
    run_cycle("R6", 2'b00, 1'b0, 1'b0, 1'b0);
    run_cycle("R4", 2'b10, 1'b0, 1'b0, 1'b0);
    run_cycle("R4", 2'b01, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_timeout_then_report;
    dma_req = 1'b1; tick();
    dma_req = 1'b0; addr_en = 1'b1; tick();
    addr_en = 1'b0; tick();
    tick(TMO - 1);
    chk("R2", "dma_err one edge before limit", dma_err, 1'b0);
    tick();
    chk("R2", "dma_err at limit", dma_err, 1'b1);
    din_strobe = 1'b1; tick();
    din_strobe = 1'b0; tick();
    chk("R7", "retry_req after first failure", retry_req, 1'b1);
    chk("R7", "host_err after first failure", host_err, 1'b0);
    tick();
    run_cycle("R8", 2'b11, 1'b1, 1'b0, 1'b1);
    tick(3);
    chk("R8", "host_err held", host_err, 1'b1);
    dma_req = 1'b1; tick();
    dma_req = 1'b0;
    chk("R8", "host_err cleared by request", host_err, 1'b0);
    chk("R5", "dma_err cleared by request", dma_err, 1'b0);
    run_cycle("R8", 2'b11, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_success_rearms;
    run_cycle("R9", 2'b00, 1'b0, 1'b0, 1'b0);
    run_cycle("R9", 2'b11, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_reply_stops;
    dma_req = 1'b1; tick();
    dma_req = 1'b0; addr_en = 1'b1; tick();
    addr_en = 1'b0; tick();
    tick(50);
    reply = 1'b1; tick();
    reply = 1'b0; tick();
    tick(2 * TMO);
    chk("R3", "no timeout after reply", dma_err, 1'b0);
  endtask

  task automatic t_req_priority;
    dma_req = 1'b1; tick();
    dma_req = 1'b0; reply = 1'b1; din_strobe = 1'b1; {par_hi, par_lo} = 2'b11; tick(2);
    reply = 1'b0; din_strobe = 1'b0; dma_req = 1'b1; tick();
    dma_req = 1'b0; {par_hi, par_lo} = 2'b00;
    chk("R5", "request wins over parity error", dma_err, 1'b0);
    chk("R5", "no retry when request wins", retry_req, 1'b0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_good();
    t_timeout_then_report();
    t_success_rearms();
    t_reply_stops();
    t_req_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule